// File: doc/BRIEF.md
# Multi-Port Flooding Frame Arbiter

This block is the central forwarding core of a full-duplex repeater with N ports. Every port places received frames in its own input FIFO. A port raises its ready flag only when at least one complete frame is stored. The core picks one ready port and reads that frame from the port's FIFO head one byte at a time. It sends each byte on one shared transmit stream. A transmit-enable mask routes the stream to every port except the source port. No address lookup takes place. Contention is resolved between the port buffers inside the core, not between stations on the links, so there is no backoff and no retry.

Ports are chosen in round-robin order. The search begins at the port after the last one granted, so a busy port cannot starve the others. A grant lasts until the end-of-frame byte has been accepted. The mask stays fixed for the whole frame. After each frame the core spends at least one idle cycle, and it chooses the next port during that cycle. A transmit port that is enabled and not ready holds the stream; no byte is dropped.

Top module: `flood_arbiter`

## Requirements
- R1: During and directly after reset, tx_valid, tx_en and rd_en are all zero.
- R2: The core is idle (tx_valid low) and at least one frm_rdy bit is high at a clock edge. Then tx_valid is high in the following cycle, even if only one port is ready. If no frm_rdy bit is high, the core stays idle.
- R3: Port selection is round-robin over ports 0..N-1 in increasing index order. The search starts at the port after the one granted last and wraps around. After reset, port 0 is searched first.
- R4: While tx_valid is high, tx_en has every bit set except the bit of the granted port. The mask does not change until the frame's last byte has been transferred.
- R5: tx_data, tx_first and tx_last show the granted port's FIFO head: its byte, its start marker and its end marker. On each transfer, rd_en pulses only the granted port's bit. Bytes leave in FIFO order.
- R6: A byte is transferred only in a cycle where every port with its tx_en bit set has tx_ready high. In any other cycle rd_en is zero and the same byte stays on tx_data.
- R7: After the transfer of a byte with tx_last high, the next cycle has tx_valid low, and tx_en and rd_en all zero.
- R8: A frame of a single byte, with the start and end markers on the same byte, is forwarded as a complete frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_rdy | input | N | Per port: at least one complete frame is in the FIFO |
| rd_data | input | N*DW | Per-port FIFO head byte, port p at bits p*DW upward |
| rd_first | input | N | Per port: head byte starts a frame |
| rd_last | input | N | Per port: head byte ends a frame |
| rd_en | output | N | Per-port FIFO pop strobe |
| tx_data | output | DW | Shared transmit byte |
| tx_valid | output | 1 | Transmit byte valid (grant active) |
| tx_first | output | 1 | Transmit byte is the first byte of a frame |
| tx_last | output | 1 | Transmit byte is the last byte of a frame |
| tx_en | output | N | Per-port transmit enable mask |
| tx_ready | input | N | Per-port transmit side can accept a byte |

## Verification
The checks assume that each input FIFO keeps to the store-and-forward rule. A port raises frm_rdy only when a whole frame, ending in a byte marked last, is already stored, and its head byte stays unchanged until it is popped. The bench keeps to this rule by design. Its FIFO model adds a frame only in one piece, and it derives frm_rdy and the head markers from that model. It also changes these inputs only half a cycle away from the sampling edge. tx_ready is driven either all high or at random. No assumption is made about it: stalls may come at any byte, including the first and the last.

// File: rtl/flood_arbiter.sv
module flood_arbiter #(
  parameter int N  = 4,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    frm_rdy,
  input  logic [N*DW-1:0] rd_data,
  input  logic [N-1:0]    rd_first,
  input  logic [N-1:0]    rd_last,
  output logic [N-1:0]    rd_en,
  output logic [DW-1:0]   tx_data,
  output logic            tx_valid,
  output logic            tx_first,
  output logic            tx_last,
  output logic [N-1:0]    tx_en,
  input  logic [N-1:0]    tx_ready
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;
  localparam logic [N-1:0] ONE = N'(1);

  logic          busy;
  logic [PW-1:0] sel, prev, pick;
  logic          found;
  logic          xfer;

  always_comb begin
    int idx;
    found = 1'b0;
    pick  = prev;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(prev) + k) % N;
      if (!found && frm_rdy[idx]) begin
        found = 1'b1;
        pick  = PW'(idx);
      end
    end
  end

  assign tx_valid = busy;
  assign tx_en    = busy ? ~(ONE << sel) : '0;
  assign tx_data  = busy ? rd_data[sel*DW +: DW] : '0;
  assign tx_first = busy & rd_first[sel];
  assign tx_last  = busy & rd_last[sel];
  assign xfer     = busy & (&(tx_ready | ~tx_en));
  assign rd_en    = xfer ? (ONE << sel) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sel  <= '0;
      prev <= PW'(N-1);
    end else if (!busy) begin
      if (found) begin
        busy <= 1'b1;
        sel  <= pick;
        prev <= pick;
      end
    end else if (xfer && tx_last) begin
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/flood_arbiter_chk.sv
module flood_arbiter_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] frm_rdy,
  input logic [N-1:0] rd_en,
  input logic         tx_valid,
  input logic         tx_last,
  input logic [N-1:0] tx_en,
  input logic [N-1:0] tx_ready
);
  logic all_ok;
  assign all_ok = ((tx_ready | ~tx_en) == '1);

  // R2
  grant_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid && frm_rdy != '0) |=> tx_valid);
  // R2
  stay_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid && frm_rdy == '0) |=> !tx_valid);
  // R4
  mask_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $countones(tx_en) == N-1);
  // R4
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !(rd_en != '0 && tx_last)) |=> $stable(tx_en));
  // R5
  pop_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_en) && ((rd_en & tx_en) == '0));
  // R6
  stall_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !all_ok) |-> rd_en == '0);
  // R7
  frame_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en != '0 && tx_last) |=> !tx_valid);
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid |-> (rd_en == '0 && tx_en == '0));
endmodule

bind flood_arbiter flood_arbiter_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_rdy(frm_rdy), .rd_en(rd_en),
  .tx_valid(tx_valid), .tx_last(tx_last), .tx_en(tx_en), .tx_ready(tx_ready)
);

// File: tb/test_flood_arbiter.sv
`timescale 1ns/1ps
module test_flood_arbiter;
  localparam int NP = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]    frm_rdy = '0;
  logic [NP*DW-1:0] rd_data = '0;
  logic [NP-1:0]    rd_first = '0, rd_last = '0;
  logic [NP-1:0]    rd_en, tx_en;
  logic [NP-1:0]    tx_ready = '1;
  logic [DW-1:0]    tx_data;
  logic             tx_valid, tx_first, tx_last;

  always #2.5 clk = ~clk;

  flood_arbiter #(.N(NP), .DW(DW)) i_flood_arbiter (
    .clk(clk), .rst_n(rst_n), .frm_rdy(frm_rdy), .rd_data(rd_data),
    .rd_first(rd_first), .rd_last(rd_last), .rd_en(rd_en),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_first(tx_first),
    .tx_last(tx_last), .tx_en(tx_en), .tx_ready(tx_ready)
  );

  logic [9:0] fq [NP][$];
  logic [9:0] exq[NP][$];
  int nframes[NP];
  int checks = 0, fails = 0;
  bit stall_mode = 0, finished = 0;
  int last_g = NP-1, pred = -1, cur_g = -1;
  bit prev_valid = 0, prev_end = 0, prev_idle_rdy = 0, prev_idle_none = 0;
  logic [NP-1:0] prev_en = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push_frame(input int p, input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      logic [9:0] w;
      w = {(i == 0), (i == len-1), 8'((seed * 7 + i * 13 + p * 29) & 8'hff)};
      fq[p].push_back(w);
      exq[p].push_back(w);
    end
    nframes[p]++;
  endtask

  function automatic int rr(input int last, input logic [NP-1:0] r);
    for (int k = 1; k <= NP; k++) if (r[(last + k) % NP]) return (last + k) % NP;
    return -1;
  endfunction

  task automatic step();
    @(negedge clk); #2;
  endtask

  always @(negedge clk) begin
    for (int p = 0; p < NP; p++) begin
      frm_rdy[p] = nframes[p] > 0;
      if (fq[p].size() > 0) begin
        rd_data[p*DW +: DW] = fq[p][0][7:0];
        rd_first[p] = fq[p][0][9];
        rd_last[p]  = fq[p][0][8];
      end else begin
        rd_data[p*DW +: DW] = '0;
        rd_first[p] = 1'b0;
        rd_last[p]  = 1'b0;
      end
      tx_ready[p] = stall_mode ? (($urandom % 3) != 0) : 1'b1;
    end
    #1;
    if (rst_n) begin
      bit xfer;
      int g;
      xfer = tx_valid && ((tx_ready | ~tx_en) == '1);
      g = -1;
      for (int p = 0; p < NP; p++) if (!tx_en[p]) g = p;
      if (prev_end) chk(!tx_valid && tx_en == '0, "R7 gap after last byte", tx_valid, 0);
      if (prev_idle_rdy) chk(tx_valid, "R2 grant after idle", tx_valid, 1);
      if (prev_idle_none) chk(!tx_valid, "R2 stay idle", tx_valid, 0);
      if (tx_valid) begin
        chk($countones(tx_en) == NP-1, "R4 mask shape", tx_en, 0);
        if (!prev_valid) begin
          chk(g == pred, "R3 round-robin grant", g, pred);
          last_g = g;
          cur_g  = g;
        end else begin
          chk(tx_en == prev_en, "R4 mask held", tx_en, prev_en);
        end
        if (cur_g >= 0 && fq[cur_g].size() > 0) begin
          chk(tx_first == fq[cur_g][0][9] && tx_last == fq[cur_g][0][8],
              "R5 markers", {tx_first, tx_last}, fq[cur_g][0][9:8]);
        end
      end
      if (xfer && cur_g >= 0) begin
        logic [9:0] e;
        chk(rd_en == (NP'(1) << cur_g), "R5 pop only granted port", rd_en, NP'(1) << cur_g);
        if (exq[cur_g].size() > 0) begin
          e = exq[cur_g].pop_front();
          chk(tx_data == e[7:0], "R5 byte order", tx_data, e[7:0]);
          if (e[9] && e[8]) chk(tx_first && tx_last, "R8 single-byte frame", {tx_first, tx_last}, 3);
        end
      end else begin
        chk(rd_en == '0, tx_valid ? "R6 no pop during stall" : "R7 no pop when idle", rd_en, 0);
      end
      prev_end = xfer && tx_last;
      prev_valid = tx_valid;
      prev_en = tx_en;
      prev_idle_rdy  = !tx_valid && frm_rdy != '0;
      prev_idle_none = !tx_valid && frm_rdy == '0;
      if (!tx_valid) pred = rr(last_g, frm_rdy);
      if (xfer && cur_g >= 0 && fq[cur_g].size() > 0) begin
        logic [9:0] h;
        h = fq[cur_g].pop_front();
        if (h[8]) nframes[cur_g]--;
      end
    end
  end

  task automatic drain();
    int guard;
    guard = 0;
    while (guard < 20000) begin
      bit empty;
      empty = 1;
      for (int p = 0; p < NP; p++) if (fq[p].size() != 0) empty = 0;
      if (empty && !tx_valid) break;
      step();
      guard++;
    end
    step();
  endtask

  initial begin
    #100000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) nframes[p] = 0;
    repeat (3) step();
    chk(tx_valid == 0 && tx_en == '0 && rd_en == '0, "R1 reset outputs", {tx_valid, tx_en}, 0);
    rst_n = 1'b1;
    step();
    chk(tx_valid == 0 && tx_en == '0 && rd_en == '0, "R1 after reset", {tx_valid, tx_en}, 0);
    repeat (3) step();

    push_frame(2, 5, 1);
    drain();

    for (int p = 0; p < NP; p++) push_frame(p, 3 + p, 10 + p);
    drain();

    push_frame(1, 4, 20);
    push_frame(3, 1, 21);
    push_frame(0, 6, 22);
    drain();

    push_frame(0, 1, 30);
    drain();

    stall_mode = 1;
    for (int r = 0; r < 3; r++)
      for (int p = 0; p < NP; p++) push_frame(p, 2 + ((p + r) % 4), 40 + r * 4 + p);
    drain();

    for (int i = 0; i < 12; i++) begin
      push_frame(i % NP, 1 + (i % 5), 60 + i);
      step();
    end
    drain();
    stall_mode = 0;

    for (int p = 0; p < NP; p++) push_frame(p, 1, 80 + p);
    drain();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule